// File: doc/BRIEF.md
# Branch Annul and Stall Controller

This block steers the front end of a four-stage in-order pipeline: fetch, register read, ALU and write-back. It holds the instruction words of the register-read, ALU and write-back stages. From them it works out two things: whether the front of the pipe must wait for a result, and whether a branch now in register read changes the fetch stream. It drives a next-PC select, load enables for the fetch and register-read stage registers, and a select that puts a bubble into the ALU stage. The register file, the PC adder and any forwarding paths are outside the block.

A branch is decided early, in the register-read stage, by testing whether its Ra operand is zero. The register file's combinational read returns that operand on `raValue`. Only the one instruction fetched behind the branch can be in flight. When the branch is taken, that instruction is replaced by a harmless NOP, so the delay slot never writes a register or memory. No results are forwarded. A read of a register that an older instruction in the ALU or write-back stage is about to write holds fetch and register read, and bubbles go down the pipe until the write lands in the register file. The register file is written on the clock edge at the end of write-back.

Top module: `fe_annul_stall_ctl`

## Requirements
- R1: While `rstN` is low (asynchronous, active low), all three stage instruction words are the NOP word 32'hC3FF0000. On release, `pcSel` is 0, `ifEn`=`rfEn`=1, `aluNop`=0, `rfAnnul`=0, and `wbRegWe`=`wbMemWe`=0.
- R2: Instruction fields are opcode [31:26], Rc [25:21], Ra [20:16] and Rb [15:11]. Opcode 10xxxx reads Ra and Rb and writes Rc. Opcode 11xxxx reads Ra and writes Rc. Opcode 011001 (store) reads Ra and Rb and writes memory. Opcode 011100 (branch if zero) and 011101 (branch if nonzero) read Ra and write Rc. Any other opcode reads and writes nothing. Register 31 is a constant zero: reading it never causes a hazard, and writing it never raises a write enable.
- R3: A hazard exists when a register the register-read instruction reads equals the register written by the ALU-stage or write-back-stage instruction. While the hazard lasts, `pcSel`=2 (hold), `ifEn`=`rfEn`=0 and `aluNop`=1, and the register-read instruction stays in place.
- R4: A producer in the ALU stage stalls its dependent instruction for exactly 2 cycles. A producer in write-back stalls it for exactly 1 cycle.
- R5: With no hazard, a branch in register read is taken when the opcode is 011100 and `raValue` is zero, or the opcode is 011101 and `raValue` is nonzero. In that same cycle `pcSel`=1 and `rfAnnul`=1.
- R6: After a taken branch, the delay-slot instruction enters register read as the NOP word. When it reaches write-back, `wbRegWe` and `wbMemWe` are 0.
- R7: A stall takes priority over a branch. A branch waiting on a hazard gives `pcSel`=2 and `rfAnnul`=0 whatever `raValue` is.
- R8: `wbRegWe` is 1 with `wbRegAddr`=Rc when the write-back instruction writes a register other than 31. `wbMemWe` is 1 when the write-back instruction is a store.
- R9: A branch that is not taken gives `pcSel`=0 and `rfAnnul`=0, and the instruction behind it moves on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchInstr | input | 32 | Instruction word currently in fetch |
| raValue | input | DATA_W | Register-file read of the register-read instruction's Ra |
| pcSel | output | 2 | 0 next sequential, 1 branch target, 2 hold |
| ifEn | output | 1 | Load enable of the fetch stage (PC) register |
| rfEn | output | 1 | Load enable of the register-read instruction register |
| aluNop | output | 1 | Selects a NOP into the ALU-stage instruction register |
| rfAnnul | output | 1 | Selects a NOP into the register-read instruction register |
| raAddr | output | 5 | Ra field of the register-read instruction |
| rbAddr | output | 5 | Rb field of the register-read instruction |
| aluInstr | output | 32 | Instruction word in the ALU stage |
| wbInstr | output | 32 | Instruction word in write-back |
| wbRegWe | output | 1 | Register-file write enable at write-back |
| wbRegAddr | output | 5 | Register-file write address at write-back |
| wbMemWe | output | 1 | Memory write enable at write-back |

## Verification
The select and enable outputs depend combinationally on the stage words and `raValue`. They are due in the same cycle that an instruction sits in register read. The write-back enables follow the fetched word by three clock edges, plus one edge for each stall cycle in between. The bench changes its inputs just after a rising edge and samples at the next falling edge. Each vector in its table gives the expected outputs for that exact cycle, worked out from the number of stage registers between fetch and write-back.

// File: rtl/fasc_pkg.sv
package fasc_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int REG_AW  = 5;
  localparam int OPC_LSB = 26;
  localparam int RC_LSB  = 21;
  localparam int RA_LSB  = 16;
  localparam int RB_LSB  = 11;
  localparam logic [REG_AW-1:0] ZERO_REG = REG_AW'((1 << REG_AW) - 1);
  localparam int STAGES  = 3;

  // canonical bubble: add-constant of zero into the zero register
  localparam logic [INSTR_W-1:0] NOP_WORD = 32'hC3FF0000;

  localparam logic [OPC_W-1:0] OPC_STORE = 6'b011001;
  localparam logic [OPC_W-1:0] OPC_BRZ   = 6'b011100;
  localparam logic [OPC_W-1:0] OPC_BRNZ  = 6'b011101;

  typedef enum logic [1:0] {
    PC_NEXT   = 2'd0,
    PC_BRANCH = 2'd1,
    PC_HOLD   = 2'd2
  } pcSel_e;

  typedef struct packed {
    logic              readsRa;
    logic              readsRb;
    logic              writesRc;
    logic              isStore;
    logic              isBranch;
    logic              brOnZero;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [REG_AW-1:0] rc;
  } decInfo_t;

  typedef struct packed {
    logic holdFront;
    logic annulRf;
    logic injectNop;
  } ctlStrobe_t;
endpackage

// File: rtl/fasc_decode.sv
module fasc_decode
  import fasc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decInfo_t           info
);
  logic [OPC_W-1:0] opc;

  always_comb begin
    opc  = instr[OPC_LSB +: OPC_W];
    info = '0;
    info.ra = instr[RA_LSB +: REG_AW];
    info.rb = instr[RB_LSB +: REG_AW];
    info.rc = instr[RC_LSB +: REG_AW];
    if (opc[OPC_W-1 -: 2] == 2'b10) begin
      info.readsRa  = 1'b1;
      info.readsRb  = 1'b1;
      info.writesRc = 1'b1;
    end else if (opc[OPC_W-1 -: 2] == 2'b11) begin
      info.readsRa  = 1'b1;
      info.writesRc = 1'b1;
    end else if (opc == OPC_STORE) begin
      info.readsRa = 1'b1;
      info.readsRb = 1'b1;
      info.isStore = 1'b1;
    end else if (opc == OPC_BRZ || opc == OPC_BRNZ) begin
      info.readsRa  = 1'b1;
      info.writesRc = 1'b1;
      info.isBranch = 1'b1;
      info.brOnZero = (opc == OPC_BRZ);
    end
    // the zero register carries no dependence in either direction
    if (info.ra == ZERO_REG) info.readsRa  = 1'b0;
    if (info.rb == ZERO_REG) info.readsRb  = 1'b0;
    if (info.rc == ZERO_REG) info.writesRc = 1'b0;
  end
endmodule

// File: rtl/fasc_ir_path.sv
module fasc_ir_path
  import fasc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  ctlStrobe_t         strobe,
  output logic [INSTR_W-1:0] rfInstr,
  output logic [INSTR_W-1:0] aluInstr,
  output logic [INSTR_W-1:0] wbInstr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rfInstr  <= NOP_WORD;
      aluInstr <= NOP_WORD;
      wbInstr  <= NOP_WORD;
    end else begin
      if (!strobe.holdFront)
        rfInstr <= strobe.annulRf ? NOP_WORD : fetchInstr;
      aluInstr <= strobe.injectNop ? NOP_WORD : rfInstr;
      wbInstr  <= aluInstr;
    end
  end
endmodule

// File: rtl/fasc_ctl.sv
module fasc_ctl
  import fasc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  decInfo_t          decRf,
  input  decInfo_t          decAlu,
  input  decInfo_t          decWb,
  input  logic [DATA_W-1:0] raValue,
  output ctlStrobe_t        strobe,
  output logic [1:0]        pcSel
);
  localparam int NPROD = STAGES - 1;

  decInfo_t producer [NPROD];
  logic     raHit, rbHit, stall, raZero, taken;
  logic     unusedInfo;

  assign producer[0] = decAlu;
  assign producer[1] = decWb;
  assign unusedInfo  = ^{decRf, decAlu, decWb};

  always_comb begin
    raHit = 1'b0;
    rbHit = 1'b0;
    for (int p = 0; p < NPROD; p++) begin
      if (producer[p].writesRc) begin
        if (decRf.readsRa && producer[p].rc == decRf.ra) raHit = 1'b1;
        if (decRf.readsRb && producer[p].rc == decRf.rb) rbHit = 1'b1;
      end
    end
    stall  = raHit | rbHit;
    raZero = (raValue == '0);
    taken  = decRf.isBranch && !stall && (decRf.brOnZero ? raZero : !raZero);

    strobe.holdFront = stall;
    strobe.injectNop = stall;
    strobe.annulRf   = taken;

    if (stall)      pcSel = PC_HOLD;
    else if (taken) pcSel = PC_BRANCH;
    else            pcSel = PC_NEXT;
  end
endmodule

// File: rtl/fe_annul_stall_ctl.sv
module fe_annul_stall_ctl
  import fasc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [INSTR_W-1:0]   fetchInstr,
  input  logic [DATA_W-1:0]    raValue,
  output logic [1:0]           pcSel,
  output logic                 ifEn,
  output logic                 rfEn,
  output logic                 aluNop,
  output logic                 rfAnnul,
  output logic [REG_AW-1:0]    raAddr,
  output logic [REG_AW-1:0]    rbAddr,
  output logic [INSTR_W-1:0]   aluInstr,
  output logic [INSTR_W-1:0]   wbInstr,
  output logic                 wbRegWe,
  output logic [REG_AW-1:0]    wbRegAddr,
  output logic                 wbMemWe
);
  ctlStrobe_t         strobe;
  logic [INSTR_W-1:0] rfInstr;
  logic [INSTR_W-1:0] stageInstr [STAGES];
  decInfo_t           stageInfo  [STAGES];
  logic               unusedTop;

  fasc_ir_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .fetchInstr(fetchInstr),
    .strobe    (strobe),
    .rfInstr   (rfInstr),
    .aluInstr  (aluInstr),
    .wbInstr   (wbInstr)
  );

  assign stageInstr[0] = rfInstr;
  assign stageInstr[1] = aluInstr;
  assign stageInstr[2] = wbInstr;

  for (genvar g = 0; g < STAGES; g++) begin : gDec
    fasc_decode u_dec (
      .instr(stageInstr[g]),
      .info (stageInfo[g])
    );
  end

  fasc_ctl #(.DATA_W(DATA_W)) u_ctl (
    .decRf  (stageInfo[0]),
    .decAlu (stageInfo[1]),
    .decWb  (stageInfo[2]),
    .raValue(raValue),
    .strobe (strobe),
    .pcSel  (pcSel)
  );

  assign ifEn      = !strobe.holdFront;
  assign rfEn      = !strobe.holdFront;
  assign aluNop    = strobe.injectNop;
  assign rfAnnul   = strobe.annulRf;
  assign raAddr    = rfInstr[RA_LSB +: REG_AW];
  assign rbAddr    = rfInstr[RB_LSB +: REG_AW];
  assign wbRegWe   = stageInfo[2].writesRc;
  assign wbRegAddr = stageInfo[2].rc;
  assign wbMemWe   = stageInfo[2].isStore;
  assign unusedTop = ^{stageInfo[0], stageInfo[1], stageInfo[2]};
endmodule

// File: rtl/fasc_chk.sv
module fasc_chk
  import fasc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         pcSel,
  input logic               ifEn,
  input logic               rfEn,
  input logic               aluNop,
  input logic               rfAnnul,
  input logic [REG_AW-1:0]  raAddr,
  input logic [INSTR_W-1:0] aluInstr,
  input logic               wbRegWe,
  input logic [REG_AW-1:0]  wbRegAddr,
  input logic               wbMemWe
);
  logic [1:0] holdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  holdRun <= 2'd0;
    else if (pcSel == PC_HOLD)  holdRun <= (holdRun == 2'd3) ? 2'd3 : holdRun + 2'd1;
    else                        holdRun <= 2'd0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!wbRegWe && !wbMemWe && pcSel == PC_NEXT));

  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rstN)
    wbRegWe |-> (wbRegAddr != ZERO_REG));

  assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pcSel == PC_HOLD) |-> (!ifEn && !rfEn && aluNop));

  assert_frozen_rf_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rfEn |=> $stable(raAddr));

  assert_stall_max_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pcSel == PC_HOLD) |-> (holdRun <= 2'd1));

  assert_taken_redirect_R5: assert property (@(posedge clk) disable iff (!rstN)
    rfAnnul |-> (pcSel == PC_BRANCH && rfEn));

  assert_annul_bubble_R6: assert property (@(posedge clk) disable iff (!rstN)
    rfAnnul |-> ##2 (aluInstr == NOP_WORD));

  assert_stall_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    aluNop |-> !rfAnnul);
endmodule

bind fe_annul_stall_ctl fasc_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pcSel    (pcSel),
  .ifEn     (ifEn),
  .rfEn     (rfEn),
  .aluNop   (aluNop),
  .rfAnnul  (rfAnnul),
  .raAddr   (raAddr),
  .aluInstr (aluInstr),
  .wbRegWe  (wbRegWe),
  .wbRegAddr(wbRegAddr),
  .wbMemWe  (wbMemWe)
);

// File: tb/fe_annul_stall_ctl_tb.sv
module fe_annul_stall_ctl_tb;
  localparam int DW = 32;
  localparam logic [31:0] NOPW = 32'hC3FF0000;

  function automatic logic [31:0] fAlu(logic [4:0] rc, logic [4:0] ra, logic [4:0] rb);
    return {6'b100000, rc, ra, rb, 11'd0};
  endfunction
  function automatic logic [31:0] fAluc(logic [4:0] rc, logic [4:0] ra, logic [15:0] lit);
    return {6'b110000, rc, ra, lit};
  endfunction
  function automatic logic [31:0] fSt(logic [4:0] ra, logic [4:0] rb);
    return {6'b011001, 5'd0, ra, rb, 11'd0};
  endfunction
  function automatic logic [31:0] fBrz(logic [4:0] rc, logic [4:0] ra);
    return {6'b011100, rc, ra, 16'd0};
  endfunction
  function automatic logic [31:0] fBrnz(logic [4:0] rc, logic [4:0] ra);
    return {6'b011101, rc, ra, 16'd0};
  endfunction

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] raVal;
    logic [1:0]  pcSel;
    logic        stall;
    logic        annul;
    logic        wbWe;
    logic [4:0]  wbAddr;
    logic        memWe;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  // one row per cycle: fetched word, Ra read value, expected outputs, requirement
  localparam vec_t VECS [NV] = '{
    '{fAluc(5'd1, 5'd31, 16'd5), 32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd1}, // R1 idle after reset
    '{fAluc(5'd2, 5'd31, 16'd7), 32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd2}, // R2 reads r31 only
    '{fAlu(5'd3, 5'd1, 5'd2),    32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd2},
    '{fAluc(5'd4, 5'd31, 16'd1), 32'd0, 2'd2, 1'b1, 1'b0, 1'b1, 5'd1,  1'b0, 8'd3}, // R3 r2 in ALU
    '{fAluc(5'd4, 5'd31, 16'd1), 32'd0, 2'd2, 1'b1, 1'b0, 1'b1, 5'd2,  1'b0, 8'd4}, // R4 second cycle
    '{fAluc(5'd4, 5'd31, 16'd1), 32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd4}, // R4 released
    '{fBrz(5'd31, 5'd5),         32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd9},
    '{fAluc(5'd6, 5'd31, 16'd9), 32'd0, 2'd1, 1'b0, 1'b1, 1'b1, 5'd3,  1'b0, 8'd5}, // R5 brz taken
    '{fBrnz(5'd31, 5'd5),        32'd0, 2'd0, 1'b0, 1'b0, 1'b1, 5'd4,  1'b0, 8'd8},
    '{fAluc(5'd7, 5'd31, 16'd1), 32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd9}, // R9 brnz on zero
    '{fAluc(5'd8, 5'd31, 16'd3), 32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd6}, // R6 annulled slot in WB
    '{fBrz(5'd31, 5'd8),         32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd2}, // R2 link to r31
    '{fAluc(5'd10, 5'd31, 16'd2),32'd0, 2'd2, 1'b1, 1'b0, 1'b1, 5'd7,  1'b0, 8'd7}, // R7 branch waits
    '{fAluc(5'd10, 5'd31, 16'd2),32'd0, 2'd2, 1'b1, 1'b0, 1'b1, 5'd8,  1'b0, 8'd7},
    '{fAluc(5'd10, 5'd31, 16'd2),32'd3, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd9}, // R9 brz on nonzero
    '{fBrnz(5'd31, 5'd6),        32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd9},
    '{fSt(5'd31, 5'd31),         32'd5, 2'd1, 1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 8'd5}, // R5 brnz taken
    '{fSt(5'd31, 5'd31),         32'd0, 2'd0, 1'b0, 1'b0, 1'b1, 5'd10, 1'b0, 8'd8},
    '{NOPW,                      32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd6},
    '{NOPW,                      32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'd6}, // R6 annulled store
    '{NOPW,                      32'd0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 8'd8}  // R8 store in WB
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [31:0]   fetchInstr = NOPW;
  logic [DW-1:0] raValue = '0;
  logic [1:0]    pcSel;
  logic          ifEn, rfEn, aluNop, rfAnnul, wbRegWe, wbMemWe;
  logic [4:0]    raAddr, rbAddr, wbRegAddr;
  logic [31:0]   aluInstr, wbInstr;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  fe_annul_stall_ctl #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .fetchInstr(fetchInstr), .raValue(raValue),
    .pcSel(pcSel), .ifEn(ifEn), .rfEn(rfEn), .aluNop(aluNop), .rfAnnul(rfAnnul),
    .raAddr(raAddr), .rbAddr(rbAddr), .aluInstr(aluInstr), .wbInstr(wbInstr),
    .wbRegWe(wbRegWe), .wbRegAddr(wbRegAddr), .wbMemWe(wbMemWe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(posedge clk);
      #2;
      fetchInstr = VECS[k].instr;
      raValue    = VECS[k].raVal;
      @(negedge clk);
      begin
        logic [10:0] act, exp;
        logic        okv;
        act = {pcSel, aluNop, !ifEn, !rfEn, rfAnnul, wbRegWe,
               (wbRegWe ? wbRegAddr : 5'd0), wbMemWe};
        exp = {VECS[k].pcSel, VECS[k].stall, VECS[k].stall, VECS[k].stall,
               VECS[k].annul, VECS[k].wbWe,
               (VECS[k].wbWe ? VECS[k].wbAddr : 5'd0), VECS[k].memWe};
        act = act & 11'h7FF;
        okv = (act[10:8] == exp[10:8]) && (act[7] == exp[7]) && (act[6] == exp[6]) &&
              (act[5:0] == exp[5:0]) && (aluNop == VECS[k].stall);
        total++;
        if (!okv) begin
          bad++;
          $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                   VECS[k].req, k, act, exp);
        end
      end
    end

    // R3: directed hazard through the Ra field, then reset in the middle of the stall
    @(posedge clk); #2; fetchInstr = fAluc(5'd12, 5'd31, 16'd1); raValue = '0;
    @(posedge clk); #2; fetchInstr = fAlu(5'd13, 5'd12, 5'd31);
    @(posedge clk); #2; fetchInstr = NOPW;
    @(negedge clk);
    check(pcSel == 2'd2, "R3", "pcSel on ALU producer", 64'(pcSel), 64'd2);
    check(raAddr == 5'd12, "R3", "raAddr of waiting instr", 64'(raAddr), 64'd12);
    check(!ifEn && !rfEn, "R3", "front enables", 64'({ifEn, rfEn}), 64'd0);
    rstN = 1'b0;
    #2;
    // R1: asynchronous clear of every stage word
    check(aluInstr == NOPW, "R1", "aluInstr in reset", 64'(aluInstr), 64'(NOPW));
    check(wbInstr == NOPW, "R1", "wbInstr in reset", 64'(wbInstr), 64'(NOPW));
    check(pcSel == 2'd0 && ifEn && rfEn && !aluNop && !rfAnnul, "R1", "controls in reset",
          64'({pcSel, ifEn, rfEn, aluNop, rfAnnul}), 64'({2'd0, 1'b1, 1'b1, 1'b0, 1'b0}));
    check(!wbRegWe && !wbMemWe, "R1", "wb enables in reset",
          64'({wbRegWe, wbMemWe}), 64'd0);
    check(raAddr == 5'd31, "R1", "raAddr of NOP", 64'(raAddr), 64'd31);
    @(negedge clk);
    rstN = 1'b1;

    // R4: producer already in write-back costs a single stall cycle
    @(posedge clk); #2; fetchInstr = fAluc(5'd14, 5'd31, 16'd4);
    @(posedge clk); #2; fetchInstr = NOPW;
    @(posedge clk); #2; fetchInstr = fSt(5'd31, 5'd14);
    @(posedge clk); #2; fetchInstr = NOPW;
    @(negedge clk);
    check(pcSel == 2'd2, "R4", "WB producer stall on Rb", 64'(pcSel), 64'd2);
    @(posedge clk); #2;
    @(negedge clk);
    check(pcSel == 2'd0 && !aluNop, "R4", "one-cycle stall end", 64'(pcSel), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          total++;
          bad++;
          $display("FAIL watchdog expired actual=running expected=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule